// File: doc/BRIEF.md
# Redirected Per-Core Register Window

This block decodes a simple register bus into a control register space shared by several cores. The 32 KiB space has four 8 KiB windows: a global block, a core-local window, a core-other window and a debug block. The core-local window always lands in the requesting core's own register bank. The core-other window has no fixed target. Each requesting core owns a selector register that retargets this window. The selector can point at another core's local bank, the global block, a per-core/per-virtual-processor user bank, or a high global bank.

A core programs its selector through its own core-local window. It then reaches the chosen registers at the same register offset inside the core-other window. The storage of every bank is held inside the block. A read returns its data one cycle after the request. A write takes effect at the clock edge of the request.

Top module: `cmw_redirect_window`

## Requirements
- R1: Address bits 14:13 pick the window: 0 global (0x0000), 1 core-local (0x2000), 2 core-other (0x4000), 3 debug (0x6000). Bits 12:2 give the word offset inside the window. The global and debug blocks are plain read/write storage of GLB_REGS and DBG_REGS words.
- R2: In the core-local window, requester `req_id` reaches only its own bank. Offset 0 is its selector, offset 1 its identity word, and offsets 2 to LCL_REGS-1 are read/write scratch words.
- R3: The selector keeps a target core in bits 13:8, a target virtual processor in bits 2:0 and a block code in bits 25:24. All other bits read as zero. A selector write applies to the very next access through the core-other window.
- R4: The identity word reads CLUSTER_ID in bits 15:8 and the core number in bits 7:0, with zero elsewhere. Writes to it have no effect.
- R5: Block code 0 steers the core-other window to the target core's local bank at the same offset. A target core of 32 steers it to the global block instead.
- R6: Block code 1 steers the core-other window to the global block at the same offset. Writes through it change the word seen through the global window.
- R7: Block code 2 steers the core-other window to the user bank of the target core and virtual processor. Each such bank holds USR_REGS words, and each core/VP pair has separate storage.
- R8: Block code 3 steers the core-other window to a high global bank of GHI_REGS words, separate from the global block.
- R9: Through the core-other window, a target core that does not exist (not below NUM_CORES and not 32) reads zero and ignores writes. For block code 2 the same holds for a virtual processor not below NUM_VPS.
- R10: An offset at or beyond the depth of the targeted bank reads zero and ignores writes.
- R11: A read request raises `rsp_valid` for exactly the next cycle, with its data on `rsp_rdata`. `rsp_rdata` holds its value when no read is issued. Both are zero after reset.
- R12: Each requester's selector is independent. Core-other accesses by one requester follow only that requester's selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address within the register space |
| req_wdata | input | 32 | Write data |
| req_id | input | ID_W (2) | Index of the requesting core |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |

## Verification
The assertions assume that `req_id` always names an existing core. They also assume that at most one access is issued per cycle, and that the bus inputs are stable and known while `req_valid` is high. The stimulus drives inputs only on the falling edge and keeps `req_id` within the configured cores. It mixes directed selector settings with random selectors. The random selectors name real cores, core 32 and one absent core, with virtual processors both inside and beyond the configured count. Offsets run past every bank depth, so both the miss cases and the redirect cases appear throughout the run.

// File: rtl/cmw_pkg.sv
package cmw_pkg;
  localparam int ADDR_W    = 15;
  localparam int DATA_W    = 32;
  localparam int OFF_W     = 11;
  localparam int CORE_W    = 6;
  localparam int VP_W      = 3;
  localparam int SELF_CORE = 32;

  typedef enum logic [1:0] {
    WIN_GLB = 2'd0,
    WIN_LCL = 2'd1,
    WIN_OTH = 2'd2,
    WIN_DBG = 2'd3
  } win_e;

  typedef enum logic [1:0] {
    SEL_LOCAL  = 2'd0,
    SEL_GLOBAL = 2'd1,
    SEL_USER   = 2'd2,
    SEL_GHIGH  = 2'd3
  } redir_e;

  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_GLB  = 3'd1,
    TGT_GHI  = 3'd2,
    TGT_DBG  = 3'd3,
    TGT_LCL  = 3'd4,
    TGT_USR  = 3'd5
  } tgt_e;

  typedef struct packed {
    logic [1:0]        blk;
    logic [CORE_W-1:0] core;
    logic [VP_W-1:0]   vp;
  } sel_t;

  typedef struct packed {
    tgt_e              kind;
    logic [CORE_W-1:0] core;
    logic [VP_W-1:0]   vp;
    logic [OFF_W-1:0]  off;
  } tgt_t;

  function automatic logic [DATA_W-1:0] sel_word(sel_t s);
    return {6'b0, s.blk, 10'b0, s.core, 5'b0, s.vp};
  endfunction
endpackage

// File: rtl/cmw_flat_bank.sv
module cmw_flat_bank
  import cmw_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] word_q [DEPTH];
  logic [DEPTH-1:0]  word_we;

  always_comb begin
    for (int k = 0; k < DEPTH; k++) begin
      word_we[k] = wr_en && (idx == OFF_W'(k));
    end
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[k] <= '0;
      end else if (word_we[k]) begin
        word_q[k] <= wdata;
      end
    end

    assert_flat_hold_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && idx == OFF_W'(k)) |=> $stable(word_q[k]));
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (idx == OFF_W'(k)) rd_data = word_q[k];
    end
  end
endmodule

// File: rtl/cmw_core_bank.sv
module cmw_core_bank
  import cmw_pkg::*;
#(
  parameter int CORE_NUM   = 0,
  parameter int CLUSTER_ID = 0,
  parameter int NUM_VPS    = 2,
  parameter int LCL_REGS   = 6,
  parameter int USR_REGS   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              is_user,
  input  logic [OFF_W-1:0]  idx,
  input  logic [VP_W-1:0]   vp,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output sel_t              sel_q
);
  localparam int SCR_N = LCL_REGS - 2;
  localparam logic [DATA_W-1:0] ID_WORD = {16'b0, 8'(CLUSTER_ID), 8'(CORE_NUM)};

  sel_t              sel_d;
  logic              sel_we;
  logic [DATA_W-1:0] scr_q [SCR_N];
  logic [SCR_N-1:0]  scr_we;
  logic [DATA_W-1:0] usr_q [NUM_VPS][USR_REGS];
  logic [USR_REGS-1:0] usr_we [NUM_VPS];

  always_comb begin
    sel_we = wr_en && !is_user && (idx == '0);
    sel_d  = '{blk: wdata[25:24], core: wdata[13:8], vp: wdata[2:0]};
    for (int k = 0; k < SCR_N; k++) begin
      scr_we[k] = wr_en && !is_user && (idx == OFF_W'(k + 2));
    end
    for (int v = 0; v < NUM_VPS; v++) begin
      for (int k = 0; k < USR_REGS; k++) begin
        usr_we[v][k] = wr_en && is_user && (vp == VP_W'(v)) && (idx == OFF_W'(k));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_we) begin
      sel_q <= sel_d;
    end
  end

  for (genvar k = 0; k < SCR_N; k++) begin : g_scr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        scr_q[k] <= '0;
      end else if (scr_we[k]) begin
        scr_q[k] <= wdata;
      end
    end
  end

  for (genvar v = 0; v < NUM_VPS; v++) begin : g_vp
    for (genvar k = 0; k < USR_REGS; k++) begin : g_usr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          usr_q[v][k] <= '0;
        end else if (usr_we[v][k]) begin
          usr_q[v][k] <= wdata;
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (!is_user) begin
      if (idx == '0) begin
        rd_data = sel_word(sel_q);
      end else if (idx == OFF_W'(1)) begin
        rd_data = ID_WORD;
      end else begin
        for (int k = 0; k < SCR_N; k++) begin
          if (idx == OFF_W'(k + 2)) rd_data = scr_q[k];
        end
      end
    end else begin
      for (int v = 0; v < NUM_VPS; v++) begin
        for (int k = 0; k < USR_REGS; k++) begin
          if (vp == VP_W'(v) && idx == OFF_W'(k)) rd_data = usr_q[v][k];
        end
      end
    end
  end

  // R3 / R12: a selector changes only through a write aimed at it
  assert_sel_hold_R12 : assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !is_user && idx == '0) |=> $stable(sel_q));

  // R4: the identity word is never disturbed by a write
  assert_id_read_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (!is_user && idx == OFF_W'(1)) |-> (rd_data == ID_WORD));
endmodule

// File: rtl/cmw_decode.sv
module cmw_decode
  import cmw_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_VPS   = 2,
  parameter int GLB_REGS  = 8,
  parameter int GHI_REGS  = 4,
  parameter int DBG_REGS  = 4,
  parameter int LCL_REGS  = 6,
  parameter int USR_REGS  = 2,
  parameter int ID_W      = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ID_W-1:0]   req_id,
  input  sel_t              own_sel,
  output tgt_t              tgt
);
  win_e   win;
  redir_e redir;
  logic   core_ok;
  logic   vp_ok;
  logic   unused_addr_lsb;

  assign unused_addr_lsb = ^addr[1:0];

  always_comb begin
    win     = win_e'(addr[14:13]);
    redir   = redir_e'(own_sel.blk);
    core_ok = int'(own_sel.core) < NUM_CORES;
    vp_ok   = int'(own_sel.vp) < NUM_VPS;
    tgt      = '0;
    tgt.kind = TGT_NONE;
    tgt.off  = addr[12:2];

    unique case (win)
      WIN_GLB: tgt.kind = TGT_GLB;
      WIN_DBG: tgt.kind = TGT_DBG;
      WIN_LCL: begin
        tgt.kind = TGT_LCL;
        tgt.core = CORE_W'(req_id);
      end
      default: begin
        unique case (redir)
          SEL_GLOBAL: tgt.kind = TGT_GLB;
          SEL_GHIGH:  tgt.kind = TGT_GHI;
          SEL_LOCAL: begin
            if (int'(own_sel.core) == SELF_CORE) begin
              tgt.kind = TGT_GLB;
            end else if (core_ok) begin
              tgt.kind = TGT_LCL;
              tgt.core = own_sel.core;
            end
          end
          default: begin
            if (core_ok && vp_ok) begin
              tgt.kind = TGT_USR;
              tgt.core = own_sel.core;
              tgt.vp   = own_sel.vp;
            end
          end
        endcase
      end
    endcase

    case (tgt.kind)
      TGT_GLB: if (int'(tgt.off) >= GLB_REGS) tgt.kind = TGT_NONE;
      TGT_GHI: if (int'(tgt.off) >= GHI_REGS) tgt.kind = TGT_NONE;
      TGT_DBG: if (int'(tgt.off) >= DBG_REGS) tgt.kind = TGT_NONE;
      TGT_LCL: if (int'(tgt.off) >= LCL_REGS) tgt.kind = TGT_NONE;
      TGT_USR: if (int'(tgt.off) >= USR_REGS) tgt.kind = TGT_NONE;
      default: ;
    endcase
  end
endmodule

// File: rtl/cmw_redirect_window.sv
module cmw_redirect_window
  import cmw_pkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int NUM_VPS    = 2,
  parameter int CLUSTER_ID = 0,
  parameter int GLB_REGS   = 8,
  parameter int GHI_REGS   = 4,
  parameter int DBG_REGS   = 4,
  parameter int LCL_REGS   = 6,
  parameter int USR_REGS   = 2,
  localparam int ID_W      = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [14:0]       req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [ID_W-1:0]   req_id,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata
);
  sel_t              sel_arr [NUM_CORES];
  logic [DATA_W-1:0] core_rd [NUM_CORES];
  logic [NUM_CORES-1:0] core_we;
  sel_t              own_sel;
  tgt_t              tgt;
  logic              wr_go;
  logic              glb_we, ghi_we, dbg_we;
  logic [DATA_W-1:0] glb_rd, ghi_rd, dbg_rd;
  logic [DATA_W-1:0] mux_rd;
  logic              rsp_valid_d, rsp_valid_q;
  logic              rd_en;
  logic [DATA_W-1:0] rdata_d, rdata_q;

  always_comb begin
    own_sel = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (req_id == ID_W'(c)) own_sel = sel_arr[c];
    end
  end

  cmw_decode #(
    .NUM_CORES(NUM_CORES), .NUM_VPS(NUM_VPS), .GLB_REGS(GLB_REGS),
    .GHI_REGS(GHI_REGS), .DBG_REGS(DBG_REGS), .LCL_REGS(LCL_REGS),
    .USR_REGS(USR_REGS), .ID_W(ID_W)
  ) u_decode (
    .addr   (req_addr),
    .req_id (req_id),
    .own_sel(own_sel),
    .tgt    (tgt)
  );

  always_comb begin
    wr_go  = req_valid && req_write;
    glb_we = wr_go && (tgt.kind == TGT_GLB);
    ghi_we = wr_go && (tgt.kind == TGT_GHI);
    dbg_we = wr_go && (tgt.kind == TGT_DBG);
    for (int c = 0; c < NUM_CORES; c++) begin
      core_we[c] = wr_go && (tgt.kind == TGT_LCL || tgt.kind == TGT_USR) &&
                   (tgt.core == CORE_W'(c));
    end
  end

  cmw_flat_bank #(.DEPTH(GLB_REGS)) u_glb (
    .clk(clk), .rst_n(rst_n), .wr_en(glb_we), .idx(tgt.off),
    .wdata(req_wdata), .rd_data(glb_rd));

  cmw_flat_bank #(.DEPTH(GHI_REGS)) u_ghi (
    .clk(clk), .rst_n(rst_n), .wr_en(ghi_we), .idx(tgt.off),
    .wdata(req_wdata), .rd_data(ghi_rd));

  cmw_flat_bank #(.DEPTH(DBG_REGS)) u_dbg (
    .clk(clk), .rst_n(rst_n), .wr_en(dbg_we), .idx(tgt.off),
    .wdata(req_wdata), .rd_data(dbg_rd));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    cmw_core_bank #(
      .CORE_NUM(c), .CLUSTER_ID(CLUSTER_ID), .NUM_VPS(NUM_VPS),
      .LCL_REGS(LCL_REGS), .USR_REGS(USR_REGS)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (core_we[c]),
      .is_user(tgt.kind == TGT_USR),
      .idx    (tgt.off),
      .vp     (tgt.vp),
      .wdata  (req_wdata),
      .rd_data(core_rd[c]),
      .sel_q  (sel_arr[c])
    );
  end

  always_comb begin
    mux_rd = '0;
    unique case (tgt.kind)
      TGT_GLB: mux_rd = glb_rd;
      TGT_GHI: mux_rd = ghi_rd;
      TGT_DBG: mux_rd = dbg_rd;
      TGT_LCL, TGT_USR: begin
        for (int c = 0; c < NUM_CORES; c++) begin
          if (tgt.core == CORE_W'(c)) mux_rd = core_rd[c];
        end
      end
      default: mux_rd = '0;
    endcase
  end

  always_comb begin
    rsp_valid_d = req_valid && !req_write;
    rd_en       = rsp_valid_d;
    rdata_d     = mux_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rdata_q;

  assert_rsp_follow_R11 : assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  assert_rsp_quiet_R11 : assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> (!rsp_valid && $stable(rsp_rdata)));

  assert_miss_zero_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && tgt.kind == TGT_NONE) |=> (rsp_rdata == '0));

  assert_one_write_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({glb_we, ghi_we, dbg_we, core_we}));

  assert_local_self_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[14:13] == WIN_LCL && tgt.kind != TGT_NONE) |->
    (tgt.kind == TGT_LCL && tgt.core == CORE_W'(req_id)));
endmodule

// File: tb/cmw_redirect_window_test.sv
module cmw_redirect_window_test;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4, NV = 2, CLID = 5;
  localparam int NG = 8, NH = 4, ND = 4, NL = 6, NU = 2;
  localparam logic [31:0] SEL_MASK = 32'h0300_3F07;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  req_id = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] m_glb [NG];
  logic [31:0] m_ghi [NH];
  logic [31:0] m_dbg [ND];
  logic [31:0] m_sel [NC];
  logic [31:0] m_scr [NC][NL-2];
  logic [31:0] m_usr [NC][NV][NU];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmw_redirect_window #(
    .NUM_CORES(NC), .NUM_VPS(NV), .CLUSTER_ID(CLID), .GLB_REGS(NG),
    .GHI_REGS(NH), .DBG_REGS(ND), .LCL_REGS(NL), .USR_REGS(NU)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_id(req_id),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata));

  function automatic logic [14:0] mk(int win, int off);
    return {2'(win), 11'(off), 2'b00};
  endfunction

  function automatic logic [31:0] mksel(int blk, int core, int vp);
    return {6'b0, 2'(blk), 10'b0, 6'(core), 5'b0, 3'(vp)};
  endfunction

  function automatic logic [31:0] lcl_rd(int c, int off);
    if (off == 0) return m_sel[c];
    if (off == 1) return {16'b0, 8'(CLID), 8'(c)};
    if (off < NL) return m_scr[c][off-2];
    return '0;
  endfunction

  function automatic logic [31:0] model_rd(logic [14:0] a, int id);
    int w, off, b, c, v;
    w = int'(a[14:13]); off = int'(a[12:2]);
    case (w)
      0: return (off < NG) ? m_glb[off] : '0;
      1: return lcl_rd(id, off);
      3: return (off < ND) ? m_dbg[off] : '0;
      default: begin
        b = int'(m_sel[id][25:24]); c = int'(m_sel[id][13:8]); v = int'(m_sel[id][2:0]);
        if (b == 1 || (b == 0 && c == 32)) return (off < NG) ? m_glb[off] : '0;
        if (b == 3) return (off < NH) ? m_ghi[off] : '0;
        if (b == 0) return (c < NC) ? lcl_rd(c, off) : '0;
        if (c < NC && v < NV && off < NU) return m_usr[c][v][off];
        return '0;
      end
    endcase
  endfunction

  function automatic void lcl_wr(int c, int off, logic [31:0] d);
    if (off == 0) m_sel[c] = d & SEL_MASK;
    else if (off >= 2 && off < NL) m_scr[c][off-2] = d;
  endfunction

  function automatic void model_wr(logic [14:0] a, int id, logic [31:0] d);
    int w, off, b, c, v;
    w = int'(a[14:13]); off = int'(a[12:2]);
    case (w)
      0: if (off < NG) m_glb[off] = d;
      1: lcl_wr(id, off, d);
      3: if (off < ND) m_dbg[off] = d;
      default: begin
        b = int'(m_sel[id][25:24]); c = int'(m_sel[id][13:8]); v = int'(m_sel[id][2:0]);
        if (b == 1 || (b == 0 && c == 32)) begin
          if (off < NG) m_glb[off] = d;
        end else if (b == 3) begin
          if (off < NH) m_ghi[off] = d;
        end else if (b == 0) begin
          if (c < NC) lcl_wr(c, off, d);
        end else if (c < NC && v < NV && off < NU) begin
          m_usr[c][v][off] = d;
        end
      end
    endcase
  endfunction

  function automatic string tag_of(logic [14:0] a, int id);
    int w, b;
    w = int'(a[14:13]); b = int'(m_sel[id][25:24]);
    if (w == 1) return "R2";
    if (w != 2) return "R1";
    case (b)
      0: return "R5";
      1: return "R6";
      2: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int id, logic [14:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_id = 2'(id);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    model_wr(a, id, d);
  endtask

  task automatic rd(string tag, int id, logic [14:0] a);
    logic [31:0] exp;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_id = 2'(id);
    exp = model_rd(a, id);
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid"}, {31'b0, rsp_valid}, 32'd1);
    check(tag, rsp_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] last;
    for (int i = 0; i < NG; i++) m_glb[i] = '0;
    for (int i = 0; i < NH; i++) m_ghi[i] = '0;
    for (int i = 0; i < ND; i++) m_dbg[i] = '0;
    for (int c = 0; c < NC; c++) begin
      m_sel[c] = '0;
      for (int k = 0; k < NL-2; k++) m_scr[c][k] = '0;
      for (int v = 0; v < NV; v++) for (int k = 0; k < NU; k++) m_usr[c][v][k] = '0;
    end
    void'($urandom(32'h1234_abcd));
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 reset valid", {31'b0, rsp_valid}, 32'd0);
    check("R11 reset data", rsp_rdata, 32'd0);
    rst_n = 1'b1;

    // R4: identity words, write ignored
    for (int c = 0; c < NC; c++) rd("R4 id", c, mk(1, 1));
    wr(2, mk(1, 1), 32'hFFFF_FFFF);
    rd("R4 id after write", 2, mk(1, 1));

    // R2: scratch belongs to the requester
    wr(1, mk(1, 3), 32'hA5A5_0001);
    rd("R2 own scratch", 1, mk(1, 3));
    rd("R2 other core unaffected", 2, mk(1, 3));

    // R3: selector masking and immediate effect
    wr(0, mk(1, 0), 32'hFFFF_FFFF);
    rd("R3 selector mask", 0, mk(1, 0));
    check("R3 mask value", m_sel[0], 32'h0300_3F07);
    wr(0, mk(1, 0), mksel(0, 1, 0));
    rd("R5 redirect to core1 local", 0, mk(2, 3));
    rd("R5 redirect to core1 id", 0, mk(2, 1));

    // R5: core 32 reaches global block
    wr(0, mk(0, 4), 32'h0000_C0DE);
    wr(1, mk(1, 0), mksel(0, 32, 0));
    rd("R5 core32 global", 1, mk(2, 4));

    // R6: global redirect, write through it
    wr(3, mk(1, 0), mksel(1, 2, 0));
    wr(3, mk(2, 6), 32'h6666_0006);
    rd("R6 global via window", 0, mk(0, 6));

    // R12: requester 1 still sees its own selector
    rd("R12 independent selector", 1, mk(2, 4));

    // R7: user banks per core and vp
    wr(2, mk(1, 0), mksel(2, 2, 1));
    wr(2, mk(2, 1), 32'h7777_2101);
    wr(3, mk(1, 0), mksel(2, 2, 0));
    rd("R7 vp0 separate", 3, mk(2, 1));
    rd("R7 vp1 value", 2, mk(2, 1));

    // R8: global-high separate from global
    wr(0, mk(1, 0), mksel(3, 0, 0));
    wr(0, mk(2, 2), 32'h8888_0002);
    rd("R8 high bank", 0, mk(2, 2));
    rd("R8 global untouched", 0, mk(0, 2));

    // R9: absent core and vp
    wr(1, mk(1, 0), mksel(0, 5, 0));
    wr(1, mk(2, 2), 32'hDEAD_0009);
    rd("R9 absent core reads zero", 1, mk(2, 2));
    for (int c = 0; c < NC; c++) rd("R9 no core written", c, mk(1, 2));
    wr(1, mk(1, 0), mksel(2, 0, 3));
    wr(1, mk(2, 0), 32'hDEAD_0003);
    rd("R9 absent vp reads zero", 1, mk(2, 0));
    wr(1, mk(1, 0), mksel(2, 0, 0));
    rd("R9 vp0 unwritten", 1, mk(2, 0));

    // R10: beyond depth
    wr(0, mk(0, NG), 32'hBAD0_0010);
    rd("R10 beyond global", 0, mk(0, NG));
    rd("R10 global word0", 0, mk(0, 0));
    wr(2, mk(3, 1), 32'h0DB6_0001);
    rd("R1 debug block", 2, mk(3, 1));
    rd("R10 beyond debug", 2, mk(3, ND));

    // R11: data holds across idle cycles
    last = rsp_rdata;
    @(negedge clk);
    check("R11 idle valid", {31'b0, rsp_valid}, 32'd0);
    check("R11 idle hold", rsp_rdata, last);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int id, op, w, off, pick, core;
      logic [31:0] s;
      logic [14:0] a;
      id = int'($urandom % NC);
      op = int'($urandom % 10);
      w = int'($urandom % 4);
      off = int'($urandom % 9);
      a = mk(w, off);
      if (op < 2) begin
        pick = int'($urandom % 6);
        core = (pick < 4) ? pick : ((pick == 4) ? 5 : 32);
        s = $urandom;
        s[25:24] = 2'($urandom % 4);
        s[13:8] = 6'(core);
        s[2:0] = 3'($urandom % 4);
        wr(id, mk(1, 0), s);
      end else if (op < 6) begin
        rd(tag_of(a, id), id, a);
      end else begin
        wr(id, a, $urandom);
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule